// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical one. It reads two levels of translation tables that sit in ordinary memory. A requester hands over a virtual address, a supervisor/user flag and a read/write flag. The walker first fetches a segment entry from the table for that mode. It then fetches the page entry that the segment entry points at. It answers with the physical address and the page's cache-inhibit attribute, or with a fault. On a successful walk it writes the page entry back with its reference flag set, and on a write access with its modify flag set too. It issues that write-back only when a flag actually changes.

Configuration writes load the two table roots and the control word. A root is given as a frame number, that is, the physical address shifted right by the page size. The control word holds the per-mode translation enables and four sticky fault flags. The hardware only sets those flags, and only a configuration write clears them. When translation is disabled for the request's mode, the address passes through unchanged and no memory cycle takes place. The walker serves one request at a time.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid`, `mem_req` and all 16 bits of `status` are 0.
- R2: If translation is disabled for the request's mode, the response carries `rsp_paddr` equal to `req_vaddr`, with `rsp_fault`, `rsp_translated` and `rsp_nocache` all 0, and the walker makes no memory access.
- R3: The segment entry is read at `{root, va[31:22], 2'b00}`. The page entry is read at `{seg_entry[31:12], va[21:12], 2'b00}`. A successful walk returns `rsp_paddr = {page_entry[31:12], va[11:0]}` with `rsp_translated` = 1, and `rsp_nocache` equals page-entry bit 6. `mem_req` and `mem_addr` stay steady until `mem_ack`.
- R4: Supervisor requests walk from the root loaded with `cfg_sel` = 0. User requests walk from the root loaded with `cfg_sel` = 1. A root takes bits 19:0 of `cfg_wdata`.
- R5: A segment entry whose bit 1 is 0 gives a fault response and sets `status` bit 15. No page entry is read.
- R6: A page entry whose bit 0 is 0 gives a fault response and sets `status` bit 14.
- R7: A write request to a segment entry with bit 2 set, or to a page entry with bit 2 set, gives a fault response and sets `status` bit 13. Read requests to such entries succeed.
- R8: Every fault also sets `status` bit 3. A fault response has `rsp_paddr` = 0 and `rsp_translated` = 0. Bits 15, 14, 13 and 3 keep their value until a configuration write with `cfg_sel` = 2 loads them from the same bit positions of `cfg_wdata`.
- R9: After a successful walk, the page entry in memory has bit 3 (reference) set, and on a write access bit 4 (modify) set too. Exactly one memory write occurs if that changes the entry and none otherwise. A fault causes no memory write.
- R10: `req_ready` is low from the cycle after a request is accepted until the response, and `rsp_valid` is high for exactly one cycle per request.
- R11: A configuration write with `cfg_sel` = 2 sets the user enable from `cfg_wdata` bit 0 and the supervisor enable from bit 1. These appear as `status` bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted on this edge |
| req_vaddr | input | 32 | Virtual address |
| req_super | input | 1 | 1 = supervisor space, 0 = user space |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_fault | output | 1 | Translation failed |
| rsp_translated | output | 1 | Address came from the tables |
| rsp_nocache | output | 1 | Page marked cache-inhibited |
| rsp_paddr | output | 32 | Physical address |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory cycle done, read data valid |
| mem_rdata | input | 32 | Memory read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 supervisor root, 1 user root, 2 control word |
| cfg_wdata | input | 32 | Configuration write data |
| status | output | 16 | Control word: enables and sticky fault flags |

## Verification
The bench builds the walker with the default page shift of 12. That gives 32-bit addresses, 1024-entry tables and 4 MB segments, so every address field sits at the bit positions the requirements name. Random addresses are drawn from the first eight segment and page indices plus one unfilled index. This keeps valid walks, missing entries, read-only levels and already-marked entries all frequent. The bench also turns each mode's enable on and off, and it clears the sticky flags partway through the run.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_FETCH_SEG,
    WK_EVAL_SEG,
    WK_FETCH_PG,
    WK_EVAL_PG,
    WK_MARK_PG,
    WK_REPLY
  } walk_state_t;

  // entry bit positions decoded by the walker
  localparam int SEG_OK_BIT  = 1;
  localparam int SEG_RO_BIT  = 2;
  localparam int PG_OK_BIT   = 0;
  localparam int PG_RO_BIT   = 2;
  localparam int PG_REF_BIT  = 3;
  localparam int PG_MOD_BIT  = 4;
  localparam int PG_NC_BIT   = 6;

  // control word positions
  localparam int CW_UEN  = 0;
  localparam int CW_SEN  = 1;
  localparam int CW_BERR = 3;
  localparam int CW_PROT = 13;
  localparam int CW_PGF  = 14;
  localparam int CW_SEGF = 15;

  localparam logic [1:0] SEL_SUP_ROOT = 2'd0;
  localparam logic [1:0] SEL_USR_ROOT = 2'd1;
  localparam logic [1:0] SEL_CTRL     = 2'd2;

endpackage

// File: rtl/pgwalk_judge.sv
module pgwalk_judge #(
  parameter int EW      = 32,
  parameter int OK_BIT  = 0,
  parameter int RO_BIT  = 2
) (
  input  logic [EW-1:0] entry,
  input  logic          is_write,
  output logic          missing,
  output logic          denied
);
  logic unused_entry;
  assign unused_entry = ^entry;

  always_comb begin
    missing = ~entry[OK_BIT];
    denied  = entry[OK_BIT] & is_write & entry[RO_BIT];
  end
endmodule

// File: rtl/pgwalk_regs.sv
module pgwalk_regs
  import pgwalk_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PFN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [VA_W-1:0]  cfg_wdata,
  input  logic             hit_segf,
  input  logic             hit_pgf,
  input  logic             hit_prot,
  output logic [PFN_W-1:0] root_sup,
  output logic [PFN_W-1:0] root_usr,
  output logic             en_sup,
  output logic             en_usr,
  output logic [15:0]      status
);
  logic f_seg, f_pg, f_prot, f_berr;
  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      root_sup <= '0;
      root_usr <= '0;
      en_sup   <= 1'b0;
      en_usr   <= 1'b0;
      f_seg    <= 1'b0;
      f_pg     <= 1'b0;
      f_prot   <= 1'b0;
      f_berr   <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          SEL_SUP_ROOT: root_sup <= cfg_wdata[PFN_W-1:0];
          SEL_USR_ROOT: root_usr <= cfg_wdata[PFN_W-1:0];
          SEL_CTRL: begin
            en_usr <= cfg_wdata[CW_UEN];
            en_sup <= cfg_wdata[CW_SEN];
            f_seg  <= cfg_wdata[CW_SEGF];
            f_pg   <= cfg_wdata[CW_PGF];
            f_prot <= cfg_wdata[CW_PROT];
            f_berr <= cfg_wdata[CW_BERR];
          end
          default: ;
        endcase
      end
      // hardware sets win over a same-cycle software write
      if (hit_segf) f_seg  <= 1'b1;
      if (hit_pgf)  f_pg   <= 1'b1;
      if (hit_prot) f_prot <= 1'b1;
      if (hit_segf | hit_pgf | hit_prot) f_berr <= 1'b1;
    end
  end

  always_comb begin
    status          = '0;
    status[CW_UEN]  = en_usr;
    status[CW_SEN]  = en_sup;
    status[CW_BERR] = f_berr;
    status[CW_PROT] = f_prot;
    status[CW_PGF]  = f_pg;
    status[CW_SEGF] = f_seg;
  end

  // R8
  berr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(f_berr) && !$past(cfg_we && cfg_sel == SEL_CTRL)) |-> f_berr);

  // R5
  segf_flag_chk: assert property (@(posedge clk) disable iff (rst)
    hit_segf |=> (status[CW_SEGF] && status[CW_BERR]));

  // R6
  pgf_flag_chk: assert property (@(posedge clk) disable iff (rst)
    hit_pgf |=> (status[CW_PGF] && status[CW_BERR]));
endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int VA_W       = 32,
  parameter int PFN_W      = 20,
  parameter int IDX_W      = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_super,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic             rsp_translated,
  output logic             rsp_nocache,
  output logic [VA_W-1:0]  rsp_paddr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [VA_W-1:0]  mem_addr,
  output logic [VA_W-1:0]  mem_wdata,
  input  logic             mem_ack,
  input  logic [VA_W-1:0]  mem_rdata,
  input  logic [PFN_W-1:0] root_sup,
  input  logic [PFN_W-1:0] root_usr,
  input  logic             en_sup,
  input  logic             en_usr,
  output logic             hit_segf,
  output logic             hit_pgf,
  output logic             hit_prot
);
  walk_state_t      state;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [PFN_W-1:0] root_q;
  logic [VA_W-1:0]  ent_q;
  logic [VA_W-1:0]  pg_addr_q;

  logic seg_missing, seg_denied, pg_missing, pg_denied;
  logic need_mark;
  logic [VA_W-1:0] marked;

  pgwalk_judge #(.EW(VA_W), .OK_BIT(SEG_OK_BIT), .RO_BIT(SEG_RO_BIT)) u_seg_judge (
    .entry(ent_q), .is_write(wr_q), .missing(seg_missing), .denied(seg_denied));

  pgwalk_judge #(.EW(VA_W), .OK_BIT(PG_OK_BIT), .RO_BIT(PG_RO_BIT)) u_pg_judge (
    .entry(ent_q), .is_write(wr_q), .missing(pg_missing), .denied(pg_denied));

  always_comb begin
    marked = ent_q;
    marked[PG_REF_BIT] = 1'b1;
    if (wr_q) marked[PG_MOD_BIT] = 1'b1;
    need_mark = (marked != ent_q);
  end

  always_comb begin
    req_ready = (state == WK_IDLE);
    rsp_valid = (state == WK_REPLY);
    mem_req   = (state == WK_FETCH_SEG) || (state == WK_FETCH_PG) || (state == WK_MARK_PG);
    mem_we    = (state == WK_MARK_PG);
    mem_wdata = ent_q;
    case (state)
      WK_FETCH_SEG: mem_addr = {root_q, va_q[VA_W-1 -: IDX_W], 2'b00};
      WK_FETCH_PG:  mem_addr = {ent_q[VA_W-1:PAGE_SHIFT], va_q[PAGE_SHIFT +: IDX_W], 2'b00};
      WK_MARK_PG:   mem_addr = pg_addr_q;
      default:      mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= WK_IDLE;
      va_q           <= '0;
      wr_q           <= 1'b0;
      root_q         <= '0;
      ent_q          <= '0;
      pg_addr_q      <= '0;
      rsp_fault      <= 1'b0;
      rsp_translated <= 1'b0;
      rsp_nocache    <= 1'b0;
      rsp_paddr      <= '0;
      hit_segf       <= 1'b0;
      hit_pgf        <= 1'b0;
      hit_prot       <= 1'b0;
    end else begin
      hit_segf <= 1'b0;
      hit_pgf  <= 1'b0;
      hit_prot <= 1'b0;
      case (state)
        WK_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          root_q <= req_super ? root_sup : root_usr;
          if (req_super ? en_sup : en_usr) begin
            state <= WK_FETCH_SEG;
          end else begin
            rsp_paddr      <= req_vaddr;
            rsp_fault      <= 1'b0;
            rsp_translated <= 1'b0;
            rsp_nocache    <= 1'b0;
            state          <= WK_REPLY;
          end
        end
        WK_FETCH_SEG: if (mem_ack) begin
          ent_q <= mem_rdata;
          state <= WK_EVAL_SEG;
        end
        WK_EVAL_SEG: begin
          if (seg_missing || seg_denied) begin
            hit_segf       <= seg_missing;
            hit_prot       <= seg_denied;
            rsp_fault      <= 1'b1;
            rsp_translated <= 1'b0;
            rsp_nocache    <= 1'b0;
            rsp_paddr      <= '0;
            state          <= WK_REPLY;
          end else begin
            state <= WK_FETCH_PG;
          end
        end
        WK_FETCH_PG: if (mem_ack) begin
          ent_q     <= mem_rdata;
          pg_addr_q <= mem_addr;
          state     <= WK_EVAL_PG;
        end
        WK_EVAL_PG: begin
          if (pg_missing || pg_denied) begin
            hit_pgf        <= pg_missing;
            hit_prot       <= pg_denied;
            rsp_fault      <= 1'b1;
            rsp_translated <= 1'b0;
            rsp_nocache    <= 1'b0;
            rsp_paddr      <= '0;
            state          <= WK_REPLY;
          end else begin
            rsp_fault      <= 1'b0;
            rsp_translated <= 1'b1;
            rsp_nocache    <= ent_q[PG_NC_BIT];
            rsp_paddr      <= {ent_q[VA_W-1:PAGE_SHIFT], va_q[PAGE_SHIFT-1:0]};
            ent_q          <= marked;
            state          <= need_mark ? WK_MARK_PG : WK_REPLY;
          end
        end
        WK_MARK_PG: if (mem_ack) state <= WK_REPLY;
        WK_REPLY: state <= WK_IDLE;
        default: state <= WK_IDLE;
      endcase
    end
  end

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9
  wb_ref_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata[PG_REF_BIT]);

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R8
  fault_noaddr_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_translated));
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  localparam int IDX_W = PAGE_SHIFT - 2,
  localparam int VA_W  = PAGE_SHIFT + 2 * IDX_W,
  localparam int PFN_W = VA_W - PAGE_SHIFT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_super,
  input  logic            req_write,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic            rsp_translated,
  output logic            rsp_nocache,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [VA_W-1:0] mem_addr,
  output logic [VA_W-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [VA_W-1:0] mem_rdata,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [VA_W-1:0] cfg_wdata,
  output logic [15:0]     status
);
  logic [PFN_W-1:0] root_sup, root_usr;
  logic en_sup, en_usr;
  logic hit_segf, hit_pgf, hit_prot;

  pgwalk_regs #(.VA_W(VA_W), .PFN_W(PFN_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .hit_segf(hit_segf), .hit_pgf(hit_pgf), .hit_prot(hit_prot),
    .root_sup(root_sup), .root_usr(root_usr), .en_sup(en_sup), .en_usr(en_usr),
    .status(status));

  pgwalk_fsm #(.PAGE_SHIFT(PAGE_SHIFT), .VA_W(VA_W), .PFN_W(PFN_W), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_super(req_super), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_translated(rsp_translated),
    .rsp_nocache(rsp_nocache), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .root_sup(root_sup), .root_usr(root_usr), .en_sup(en_sup), .en_usr(en_usr),
    .hit_segf(hit_segf), .hit_pgf(hit_pgf), .hit_prot(hit_prot));
endmodule

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_super = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, rsp_valid, rsp_fault, rsp_translated, rsp_nocache;
  logic [31:0] rsp_paddr, mem_addr, mem_wdata;
  logic mem_req, mem_we;
  logic mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] status;

  int n_chk = 0, n_fail = 0, n_acc = 0, n_wr = 0;
  logic [31:0] mem [logic [31:0]];
  logic [19:0] root_s = 20'h00010, root_u = 20'h00011;
  logic en_s = 0, en_u = 0;
  logic [15:0] exp_flags = '0;
  bit done = 0;

  always #2 clk = ~clk;

  pgwalk_top uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_super(req_super), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_translated(rsp_translated),
    .rsp_nocache(rsp_nocache), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .status(status));

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory responder: ack one negedge after a request is seen
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        mem_ack = 1'b1;
        n_acc++;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          n_wr++;
        end else mem_rdata = rd(mem_addr);
      end
    end
  end

  task automatic cfg(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd0) root_s = d[19:0];
    if (sel == 2'd1) root_u = d[19:0];
    if (sel == 2'd2) begin
      en_u = d[0]; en_s = d[1];
      exp_flags = d[15:0] & 16'hE008;
    end
  endtask

  task automatic walk(logic [31:0] va, logic sup, logic wr, string tag);
    logic en, flt, tr, nc;
    logic [31:0] pa, ste, pte, pte_a, newpte;
    logic [15:0] fbits;
    int acc0, wr0, expw, expacc, t;
    en = sup ? en_s : en_u;
    flt = 0; tr = 0; nc = 0; pa = va; fbits = 0; expw = 0; expacc = 0;
    pte_a = 0; newpte = 0;
    if (en) begin
      pa = 0;
      ste = rd({sup ? root_s : root_u, va[31:22], 2'b00});
      expacc = 1;
      if (!ste[1]) begin flt = 1; fbits = 16'h8008; end
      else if (wr && ste[2]) begin flt = 1; fbits = 16'h2008; end
      else begin
        pte_a = {ste[31:12], va[21:12], 2'b00};
        pte = rd(pte_a);
        expacc = 2;
        if (!pte[0]) begin flt = 1; fbits = 16'h4008; end
        else if (wr && pte[2]) begin flt = 1; fbits = 16'h2008; end
        else begin
          tr = 1; nc = pte[6]; pa = {pte[31:12], va[11:0]};
          newpte = pte | 32'h8 | (wr ? 32'h10 : 32'h0);
          if (newpte != pte) begin expw = 1; expacc = 3; end
        end
      end
    end
    exp_flags |= fbits;
    acc0 = n_acc; wr0 = n_wr;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_super = sup; req_write = wr;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R10 busy"}, {31'b0, req_ready}, 32'h0);
    t = 0;
    while (!rsp_valid && t < 60) begin @(negedge clk); t++; end
    chk({tag, " R10 reply"}, {31'b0, rsp_valid}, 32'h1);
    chk({tag, (flt ? " R8 fault" : " R3 fault")}, {31'b0, rsp_fault}, {31'b0, flt});
    chk({tag, (en ? " R3 paddr" : " R2 paddr")}, rsp_paddr, pa);
    chk({tag, " R3 translated"}, {31'b0, rsp_translated}, {31'b0, tr});
    chk({tag, " R3 nocache"}, {31'b0, rsp_nocache}, {31'b0, nc});
    @(negedge clk);
    chk({tag, " R10 one-cycle"}, {31'b0, rsp_valid}, 32'h0);
    chk({tag, " R2 R5 accesses"}, n_acc - acc0, expacc);
    chk({tag, " R9 writes"}, n_wr - wr0, expw);
    if (tr) chk({tag, " R9 entry"}, rd(pte_a), newpte);
    chk({tag, " R8 flags"}, {16'b0, status & 16'hE008}, {16'b0, exp_flags});
    chk({tag, " R11 enables"}, {30'b0, status[1:0]}, {30'b0, en_s, en_u});
  endtask

  function automatic logic [31:0] va_of(int s, int p, int o);
    return {s[9:0], p[9:0], o[11:0]};
  endfunction

  initial begin
    int s, p;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 ready", {31'b0, req_ready}, 32'h1);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'h0);
    chk("R1 status", {16'b0, status}, 32'h0);

    // tables: both modes, 8 segments x 8 pages each
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 8; i++) begin
        logic [31:0] e;
        logic [19:0] fr;
        fr = 20'h00100 + 20'(m * 8 + i);
        e = {fr, 12'h008};
        if (($urandom % 4) != 0) e[1] = 1'b1;
        if (($urandom % 4) == 0) e[2] = 1'b1;
        mem[{(m == 0) ? root_s : root_u, 10'(i), 2'b00}] = e;
        for (int j = 0; j < 8; j++) begin
          logic [31:0] q;
          q = {20'($urandom), 5'($urandom), 1'($urandom), 1'b0, 1'($urandom),
               1'($urandom), 1'($urandom), 1'b0, (($urandom % 5) != 0)};
          mem[{fr, 10'(j), 2'b00}] = q;
        end
      end
    end

    // R2: both modes disabled
    walk(32'hDEAD_BEEF, 1, 0, "pass-sup");
    walk(32'h0040_1ABC, 0, 1, "pass-usr");

    cfg(2'd0, {12'b0, root_s});
    cfg(2'd1, {12'b0, root_u});
    cfg(2'd2, 32'h3);

    // R4: same address, distinct roots -> distinct tables
    mem[{root_s, 10'd9, 2'b00}] = {20'h00200, 12'h00A};
    mem[{root_u, 10'd9, 2'b00}] = {20'h00201, 12'h00A};
    mem[{20'h00200, 10'd1, 2'b00}] = {20'hAAAAA, 12'h041};
    mem[{20'h00201, 10'd1, 2'b00}] = {20'hBBBBB, 12'h001};
    walk(va_of(9, 1, 12'h123), 1, 0, "R4 sup");
    walk(va_of(9, 1, 12'h456), 0, 1, "R4 usr");
    // R9: already referenced, read -> no write; then write after modified
    walk(va_of(9, 1, 12'h010), 1, 0, "R9 noop");
    walk(va_of(9, 1, 12'h020), 0, 0, "R9 noop-usr");
    // R7: read-only page, write denied, read allowed
    mem[{20'h00200, 10'd2, 2'b00}] = {20'h12345, 12'h005};
    walk(va_of(9, 2, 12'h0), 1, 1, "R7 ro-page-wr");
    walk(va_of(9, 2, 12'h0), 1, 0, "R7 ro-page-rd");
    // R7: read-only segment
    mem[{root_u, 10'd10, 2'b00}] = {20'h00200, 12'h00E};
    walk(va_of(10, 1, 12'h0), 0, 1, "R7 ro-seg-wr");
    // R5: missing segment
    walk(va_of(700, 1, 12'h0), 1, 0, "R5 no-seg");
    // R6: missing page
    walk(va_of(9, 3, 12'h0), 1, 0, "R6 no-page");
    // R8: clear flags, keep enables
    cfg(2'd2, 32'h3);
    chk("R8 cleared", {16'b0, status}, 32'h3);

    // random mix
    for (int k = 0; k < 400; k++) begin
      s = $urandom % 9;
      p = $urandom % 9;
      walk(va_of(s, p, int'($urandom % 4096)), 1'($urandom), 1'($urandom), "rnd");
      if (k == 200) cfg(2'd2, 32'h3);
    end

    // R11: user disabled, supervisor still translates
    cfg(2'd2, 32'h2);
    walk(va_of(9, 1, 12'h777), 0, 0, "R11 usr-off");
    walk(va_of(9, 1, 12'h777), 1, 0, "R11 sup-on");
    cfg(2'd2, 32'h1);
    walk(va_of(9, 1, 12'h777), 1, 1, "R11 sup-off");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule